// File: doc/BRIEF.md
# Interrupt Mode Vector Resolver

This block finishes the entry into a maskable interrupt for an 8-bit processor core. It is started by a one-cycle request once the core has accepted an interrupt. The block captures the current interrupt mode, the table page register, the byte the interrupting device placed on the data bus during acknowledge, the return program counter and the stack pointer. It then saves the return address on the stack and computes the program counter of the service routine.

There are three modes. In mode 0 the bus byte is taken as a single-byte restart opcode. In mode 1 the bus byte is ignored and the core always goes to one fixed address. In mode 2 the page register and the raw bus byte together form a pointer into a vector table, and the block reads a 16-bit routine address from memory at that pointer. Each memory access uses a request/acknowledge handshake. A one-cycle done strobe marks the cycle in which the new PC, the new SP and the unsupported-opcode flag are valid.

Top module: `irq_vec_resolver`

## Requirements
- R1: The 2-bit mode input selects mode 0, 1 or 2. The value 3 is not a valid mode and is handled as unsupported (see R5).
- R2: In mode 0, a bus byte of the form 11ttt111 (bits 7:6 = 11, bits 2:0 = 111) makes the new PC equal to ttt×8, that is {10'b0, ttt, 3'b000}.
- R3: In mode 0, the bus byte 0xFF gives the new PC 0x0038, the same result as mode 1 with the default parameter.
- R4: In mode 1, the new PC is the parameter FIXED_VEC (default 0x0038) whatever the bus byte is.
- R5: In mode 0 with a byte that is not a restart opcode, and in mode 3, bad_op is 1 when done is asserted, new_pc equals the return PC, new_sp equals the input SP, and no memory access is made. In all other cases bad_op is 0 when done is asserted.
- R6: For a supported interrupt, the block first writes the high byte of the return PC to SP−1, then writes the low byte to SP−2. Both addresses wrap modulo 2^16. new_sp is SP−2.
- R7: In mode 2, the table pointer is {page, bus byte}. Bit 0 of the bus byte is kept, so an odd byte gives an odd pointer.
- R8: In mode 2, the new PC is read little-endian. The low byte comes from the pointer and the high byte from pointer+1, and pointer+1 wraps from 0xFFFF to 0x0000. The reads follow the two pushes.
- R9: A memory request keeps its address, its write enable and its write data unchanged until the cycle in which mem_ack is high.
- R10: done is high for exactly one cycle per accepted interrupt. While busy is high, irq_req and changes on the captured inputs have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Start pulse for an accepted interrupt |
| mode | input | 2 | Interrupt mode |
| tbase | input | 8 | Vector table page (pointer high byte) |
| ack_byte | input | 8 | Data bus byte captured during acknowledge |
| ret_pc | input | 16 | Return address to save |
| sp_in | input | 16 | Stack pointer before the push |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while mem_ack is high |
| mem_ack | input | 1 | Completes the current access |
| new_pc | output | 16 | Service routine address |
| new_sp | output | 16 | Stack pointer after the push |
| done | output | 1 | One-cycle result strobe |
| bad_op | output | 1 | Unsupported mode or opcode, valid with done |
| busy | output | 1 | Resolution in progress |

## Verification
The bench builds the block with FIXED_VEC left at 0x0038. With that value the mode 0 restart 0xFF and mode 1 must give the same target, so a wrong restart decode or a wrong constant shows up as a mismatch between two paths. The memory model answers each access after a random wait of zero to two cycles. This exercises request holding and lets interfering requests land in every state of a resolution. Directed cases place the table pointer at 0xFFFF and the stack pointer at 0x0001, so both wrap-arounds are reached.

// File: rtl/irq_vec_resolver.sv
module irq_vec_resolver #(
  parameter logic [15:0] FIXED_VEC = 16'h0038
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic [1:0]  mode,
  input  logic [7:0]  tbase,
  input  logic [7:0]  ack_byte,
  input  logic [15:0] ret_pc,
  input  logic [15:0] sp_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  output logic [15:0] new_pc,
  output logic [15:0] new_sp,
  output logic        done,
  output logic        bad_op,
  output logic        busy
);
  typedef enum logic [2:0] {S_IDLE, S_PUSH_H, S_PUSH_L, S_RD_L, S_RD_H, S_FIN} st_t;

  st_t         st;
  logic [1:0]  md;
  logic [7:0]  byt, page, lo;
  logic [15:0] ret_l, sp_l;
  logic        bad;

  wire        in_rst = (ack_byte[7:6] == 2'b11) && (ack_byte[2:0] == 3'b111);
  wire        in_bad = (mode == 2'd3) || ((mode == 2'd0) && !in_rst);
  wire [15:0] ptr    = {page, byt};

  assign mem_req   = (st == S_PUSH_H) || (st == S_PUSH_L) || (st == S_RD_L) || (st == S_RD_H);
  assign mem_we    = (st == S_PUSH_H) || (st == S_PUSH_L);
  assign mem_wdata = (st == S_PUSH_H) ? ret_l[15:8] : ret_l[7:0];
  assign done      = (st == S_FIN);
  assign busy      = (st != S_IDLE);
  assign bad_op    = bad;

  always_comb begin
    case (st)
      S_PUSH_H: mem_addr = sp_l - 16'd1;
      S_PUSH_L: mem_addr = sp_l - 16'd2;
      S_RD_L:   mem_addr = ptr;
      S_RD_H:   mem_addr = ptr + 16'd1;
      default:  mem_addr = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      md     <= 2'd0;
      byt    <= 8'h00;
      page   <= 8'h00;
      lo     <= 8'h00;
      ret_l  <= 16'h0000;
      sp_l   <= 16'h0000;
      bad    <= 1'b0;
      new_pc <= 16'h0000;
      new_sp <= 16'h0000;
    end else begin
      case (st)
        S_IDLE:
          if (irq_req) begin
            md    <= mode;
            byt   <= ack_byte;
            page  <= tbase;
            ret_l <= ret_pc;
            sp_l  <= sp_in;
            bad   <= in_bad;
            if (in_bad) begin
              new_pc <= ret_pc;
              new_sp <= sp_in;
              st     <= S_FIN;
            end else begin
              st <= S_PUSH_H;
            end
          end
        S_PUSH_H:
          if (mem_ack) st <= S_PUSH_L;
        S_PUSH_L:
          if (mem_ack) begin
            new_sp <= sp_l - 16'd2;
            if (md == 2'd2) begin
              st <= S_RD_L;
            end else begin
              new_pc <= (md == 2'd0) ? {10'b0, byt[5:3], 3'b000} : FIXED_VEC;
              st     <= S_FIN;
            end
          end
        S_RD_L:
          if (mem_ack) begin
            lo <= mem_rdata;
            st <= S_RD_H;
          end
        S_RD_H:
          if (mem_ack) begin
            new_pc <= {mem_rdata, lo};
            st     <= S_FIN;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module irq_vec_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [15:0] new_pc,
  input logic [15:0] new_sp,
  input logic [15:0] ret_l,
  input logic [15:0] sp_l,
  input logic        done,
  input logic        bad_op
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_WRITE_ON_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == sp_l - 16'd1 || mem_addr == sp_l - 16'd2)); // R6
  AST_BAD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad_op) |-> (new_pc == ret_l && new_sp == sp_l)); // R5
  AST_SP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad_op) |-> (new_sp == sp_l - 16'd2)); // R6
endmodule

bind irq_vec_resolver irq_vec_resolver_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .new_pc(new_pc), .new_sp(new_sp),
  .ret_l(ret_l), .sp_l(sp_l), .done(done), .bad_op(bad_op)
);

// File: tb/irq_vec_resolver_tb_top.sv
module irq_vec_resolver_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, irq_req = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] tbase = 8'h00, ack_byte = 8'h00, mem_rdata = 8'h00;
  logic [15:0] ret_pc = 16'h0000, sp_in = 16'h0000;
  logic mem_req, mem_we, mem_ack = 1'b0, done, bad_op, busy;
  logic [15:0] mem_addr, new_pc, new_sp;
  logic [7:0] mem_wdata;

  int checks = 0, errors = 0;
  int wcount = 0, rcount = 0;
  logic [15:0] waddr [2];
  logic [7:0]  wdat [2];
  int wt = 0;
  logic fresh = 1'b1;
  logic [15:0] hold_addr;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mode(mode), .tbase(tbase),
    .ack_byte(ack_byte), .ret_pc(ret_pc), .sp_in(sp_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .new_pc(new_pc), .new_sp(new_sp), .done(done), .bad_op(bad_op),
    .busy(busy)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wt = int'($urandom % 3);
      fresh = 1'b1;
    end else if (mem_req) begin
      if (fresh) begin
        hold_addr = mem_addr;
        fresh = 1'b0;
      end
      if (wt == 0) begin
        chk(mem_addr == hold_addr, "R9 address held", {16'h0, mem_addr}, {16'h0, hold_addr});
        mem_ack = 1'b1;
        mem_rdata = mem_f(mem_addr);
        if (mem_we) begin
          if (wcount < 2) begin
            waddr[wcount] = mem_addr;
            wdat[wcount] = mem_wdata;
          end
          wcount++;
        end else begin
          rcount++;
        end
      end else begin
        wt--;
      end
    end
  end

  task automatic run(input logic [1:0] m, input logic [7:0] b, input logic [7:0] pg,
                     input logic [15:0] rp, input logic [15:0] sp, input bit intf);
    logic [15:0] e_pc, e_sp, ptr;
    bit e_bad, seen;
    int e_reads;
    e_bad = (m == 2'd3) || (m == 2'd0 && !(b[7:6] == 2'b11 && b[2:0] == 3'b111));
    ptr = {pg, b};
    e_reads = 0;
    if (e_bad) begin
      e_pc = rp; e_sp = sp;
    end else begin
      e_sp = sp - 16'd2;
      if (m == 2'd0) e_pc = {10'b0, b[5:3], 3'b000};
      else if (m == 2'd1) e_pc = 16'h0038;
      else begin
        e_pc = {mem_f(ptr + 16'd1), mem_f(ptr)};
        e_reads = 2;
      end
    end
    wcount = 0; rcount = 0;
    mode = m; ack_byte = b; tbase = pg; ret_pc = rp; sp_in = sp;
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (done) begin seen = 1'b1; break; end
      if (k == 1 && intf && !e_bad) begin
        mode = ~m; ack_byte = ~b; tbase = ~pg; ret_pc = ~rp; sp_in = ~sp;
        irq_req = 1'b1;
      end
      if (k == 2) irq_req = 1'b0;
      @(negedge clk);
    end
    irq_req = 1'b0;
    chk(seen, "R10 done reached", {31'h0, seen}, 32'h1);
    if (seen) begin
      chk(new_pc == e_pc, e_bad ? "R5 pc kept" : (m == 2'd2 ? "R7/R8 table vector" :
          (m == 2'd1 ? "R4 fixed vector" : "R2 restart vector")), {16'h0, new_pc}, {16'h0, e_pc});
      chk(new_sp == e_sp, "R6 new sp", {16'h0, new_sp}, {16'h0, e_sp});
      chk(bad_op == e_bad, "R5 bad_op", {31'h0, bad_op}, {31'h0, e_bad});
      chk(wcount == (e_bad ? 0 : 2), "R6 write count", wcount, e_bad ? 0 : 2);
      chk(rcount == e_reads, "R8 read count", rcount, e_reads);
      if (!e_bad && wcount == 2) begin
        chk(waddr[0] == sp - 16'd1 && wdat[0] == rp[15:8], "R6 high byte push",
            {waddr[0], 8'h0, wdat[0]}, {sp - 16'd1, 8'h0, rp[15:8]});
        chk(waddr[1] == sp - 16'd2 && wdat[1] == rp[7:0], "R6 low byte push",
            {waddr[1], 8'h0, wdat[1]}, {sp - 16'd2, 8'h0, rp[7:0]});
      end
      @(negedge clk);
      chk(!done, "R10 done single cycle", {31'h0, done}, 32'h0);
      chk(!busy, "R10 idle after done", {31'h0, busy}, 32'h0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_req, "R10 reset state", {29'h0, done, busy, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd0, 8'hFF, 8'h12, 16'hBEEF, 16'h8000, 1'b0);   // R3
    run(2'd1, 8'h5A, 8'h12, 16'h1234, 16'h8000, 1'b0);   // R4
    run(2'd1, 8'h00, 8'h00, 16'h4321, 16'h7FF0, 1'b1);   // R4, R10
    run(2'd0, 8'hC7, 8'h00, 16'hA5A5, 16'h9000, 1'b0);   // R2
    run(2'd0, 8'hEF, 8'h00, 16'hA5A5, 16'h9000, 1'b1);   // R2, R10
    run(2'd0, 8'h00, 8'h00, 16'h0102, 16'h9000, 1'b0);   // R5
    run(2'd3, 8'hFF, 8'h40, 16'h0304, 16'h9000, 1'b0);   // R1, R5
    run(2'd2, 8'h33, 8'h40, 16'hCAFE, 16'hD000, 1'b0);   // R7 odd pointer
    run(2'd2, 8'h32, 8'h40, 16'hCAFE, 16'hD000, 1'b1);   // R7 even pointer, R10
    run(2'd2, 8'hFF, 8'hFF, 16'h1111, 16'h0001, 1'b0);   // R8 pointer wrap, R6 sp wrap
    for (int i = 0; i < 300; i++)
      run(2'($urandom % 4), 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule